// File: doc/BRIEF.md
# CAN Bus Halt and Recovery Controller

This block owns the stopped state of a CAN protocol controller. Hardware reset, a bus-off event, or a software write of 1 to the halt bit puts the node into the stopped state. While stopped, the transmit and receive engines are disabled and the transmit line is held recessive. A software halt request is taken at once when the node is idle or only receiving; in the receiving case a one-cycle abandon pulse goes to the receive engine. The request is held back while a transmission or a message-buffer store is still running.

Leaving the stopped state always starts with a software write of 0. The block then watches the sampled RX level on every bit tick and counts runs of consecutive recessive bits. A single completed run is enough after a reset or software halt. After bus-off, the run has to complete 128 times. At that point the block sends one pulse that clears both error counters and returns the node to error active.

Top module: `can_halt_ctrl`

## Requirements
- R1: After reset, halt_status is 1, node_busoff is 0 (error active), tx_force_recessive is 1 and both engine enables are 0.
- R2: A write of 1 while running, with tx_busy and store_busy low, sets halt_status on the next clock edge. This holds even when rx_busy is high. In that case rx_abort pulses high for one cycle together with the halt.
- R3: A write of 1 while tx_busy is high leaves halt_status at 0 until the first cycle in which tx_busy (and store_busy) is low. Halt is set on the edge that ends that cycle.
- R4: A write of 1 while store_busy is high is deferred in the same way. When both busy inputs are high, halt is set only once both are low, including when both fall in the same cycle.
- R5: A write of 0 while a deferred halt is pending cancels it, and halt_status stays 0 after the busy inputs fall.
- R6: A busoff_evt pulse sets halt_status and node_busoff on the next edge in any state. node_busoff is never 1 while halt_status is 0.
- R7: After a reset or software halt, a write of 0 clears halt_status once 11 consecutive bit ticks have sampled rx_level = 1. Counting starts with the first tick in a cycle after the write, and the halt clears on the edge of the 11th tick.
- R8: A tick that samples rx_level = 0 restarts the recessive count from zero.
- R9: After bus-off, release needs 128 completed 11-bit recessive runs. On the edge of the final tick, halt_status and node_busoff both go to 0 and err_clear is 1 for exactly one cycle.
- R10: A write of 1 during recovery aborts it, and halt stays 1. A later write of 0 restarts counting from zero.
- R11: While halt_status is 1, tx_force_recessive is 1 and both engine enables are 0. A write of 0 while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_wr_en | input | 1 | Write strobe for the halt bit |
| halt_wr_data | input | 1 | Value written to the halt bit |
| bit_tick | input | 1 | One-cycle pulse at each bit sample point |
| rx_level | input | 1 | Sampled RX level, 1 = recessive |
| tx_busy | input | 1 | Transmission in progress |
| rx_busy | input | 1 | Reception in progress |
| store_busy | input | 1 | Received message being stored to a buffer |
| busoff_evt | input | 1 | One-cycle pulse on entry into bus-off |
| halt_status | output | 1 | Actual stopped state, readable by software |
| tx_force_recessive | output | 1 | Forces the TX pin recessive |
| tx_engine_en | output | 1 | Transmit engine enable |
| rx_engine_en | output | 1 | Receive engine enable |
| rx_abort | output | 1 | One-cycle pulse: drop the frame being received |
| err_clear | output | 1 | One-cycle pulse: clear both error counters |
| node_busoff | output | 1 | Node state, 1 = bus off, 0 = error active |

## Verification
The checks on deferral and release assume that bit_tick and busoff_evt are single-cycle pulses. They also assume that halt_wr_en and halt_wr_data are stable across the clock edge. The busy inputs are treated as levels that may change on any cycle. The stimulus drives every input one time unit after the rising edge and keeps it for a whole cycle. Strobes are raised for exactly one cycle. In the random phase, busy levels toggle only occasionally, so that deferrals last several cycles.

// File: rtl/can_halt_pkg.sv
package can_halt_pkg;
  typedef enum logic [1:0] {
    HS_RUN     = 2'd0,
    HS_HALTED  = 2'd1,
    HS_RECOVER = 2'd2
  } halt_state_e;
endpackage

// File: rtl/halt_req_arbiter.sv
module halt_req_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic req_set,
  input  logic req_clr,
  input  logic tx_busy,
  input  logic store_busy,
  input  logic abort,
  output logic halt_now
);
  logic pend_q, pend_d;
  logic quiet;

  assign quiet    = ~tx_busy & ~store_busy;
  assign halt_now = running & ~abort & (req_set | pend_q) & quiet;

  always_comb begin
    pend_d = pend_q;
    if (~running | abort | halt_now | req_clr) begin
      pend_d = 1'b0;
    end else if (req_set) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/idle_run_counter.sv
module idle_run_counter #(
  parameter int unsigned RUN_BITS   = 11,
  parameter int unsigned RUN_REPEAT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  input  logic rx_level,
  output logic run_done,
  output logic seq_last
);
  localparam int unsigned BIT_W = (RUN_BITS > 1) ? $clog2(RUN_BITS) : 1;
  localparam int unsigned SEQ_W = (RUN_REPEAT > 1) ? $clog2(RUN_REPEAT) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(RUN_BITS - 1);
  localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(RUN_REPEAT - 1);

  logic [BIT_W-1:0] bit_q, bit_d;
  logic [SEQ_W-1:0] seq_q, seq_d;

  assign run_done = tick & rx_level & (bit_q == BIT_LAST);
  assign seq_last = (seq_q == SEQ_LAST);

  always_comb begin
    bit_d = bit_q;
    seq_d = seq_q;
    if (clear) begin
      bit_d = '0;
      seq_d = '0;
    end else if (tick) begin
      if (!rx_level) begin
        bit_d = '0;
      end else if (run_done) begin
        bit_d = '0;
        seq_d = seq_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      seq_q <= '0;
    end else begin
      bit_q <= bit_d;
      seq_q <= seq_d;
    end
  end
endmodule

// File: rtl/can_halt_ctrl.sv
module can_halt_ctrl
  import can_halt_pkg::*;
#(
  parameter int unsigned RUN_BITS   = 11,
  parameter int unsigned RUN_REPEAT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_wr_en,
  input  logic halt_wr_data,
  input  logic bit_tick,
  input  logic rx_level,
  input  logic tx_busy,
  input  logic rx_busy,
  input  logic store_busy,
  input  logic busoff_evt,
  output logic halt_status,
  output logic tx_force_recessive,
  output logic tx_engine_en,
  output logic rx_engine_en,
  output logic rx_abort,
  output logic err_clear,
  output logic node_busoff
);
  halt_state_e state_q, state_d;
  logic busoff_q, busoff_d;
  logic clr_q, clr_d;
  logic abort_q, abort_d;
  logic wr_one, wr_zero, running, halt_now, run_done, seq_last, cnt_clear;

  assign wr_one    = halt_wr_en & halt_wr_data;
  assign wr_zero   = halt_wr_en & ~halt_wr_data;
  assign running   = (state_q == HS_RUN);
  assign cnt_clear = (state_q != HS_RECOVER);

  halt_req_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .req_set    (wr_one),
    .req_clr    (wr_zero),
    .tx_busy    (tx_busy),
    .store_busy (store_busy),
    .abort      (busoff_evt),
    .halt_now   (halt_now)
  );

  idle_run_counter #(
    .RUN_BITS   (RUN_BITS),
    .RUN_REPEAT (RUN_REPEAT)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .tick     (bit_tick),
    .rx_level (rx_level),
    .run_done (run_done),
    .seq_last (seq_last)
  );

  always_comb begin
    state_d  = state_q;
    busoff_d = busoff_q;
    clr_d    = 1'b0;
    abort_d  = 1'b0;
    if (busoff_evt) begin
      state_d  = HS_HALTED;
      busoff_d = 1'b1;
      abort_d  = running & rx_busy;
    end else begin
      unique case (state_q)
        HS_RUN: begin
          if (halt_now) begin
            state_d = HS_HALTED;
            abort_d = rx_busy;
          end
        end
        HS_HALTED: begin
          if (wr_zero) state_d = HS_RECOVER;
        end
        HS_RECOVER: begin
          if (wr_one) begin
            state_d = HS_HALTED;
          end else if (run_done && (!busoff_q || seq_last)) begin
            state_d = HS_RUN;
            if (busoff_q) begin
              busoff_d = 1'b0;
              clr_d    = 1'b1;
            end
          end
        end
        default: state_d = HS_HALTED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= HS_HALTED;
      busoff_q <= 1'b0;
      clr_q    <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      busoff_q <= busoff_d;
      clr_q    <= clr_d;
      abort_q  <= abort_d;
    end
  end

  assign halt_status        = (state_q != HS_RUN);
  assign tx_force_recessive = halt_status;
  assign tx_engine_en       = ~halt_status;
  assign rx_engine_en       = ~halt_status;
  assign rx_abort           = abort_q;
  assign err_clear          = clr_q;
  assign node_busoff        = busoff_q;
endmodule

// File: rtl/can_halt_ctrl_chk.sv
module can_halt_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_wr_en,
  input logic bit_tick,
  input logic rx_level,
  input logic tx_busy,
  input logic rx_busy,
  input logic store_busy,
  input logic busoff_evt,
  input logic halt_status,
  input logic tx_force_recessive,
  input logic tx_engine_en,
  input logic rx_engine_en,
  input logic rx_abort,
  input logic err_clear,
  input logic node_busoff
);
  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halt_status |-> tx_force_recessive && !tx_engine_en && !rx_engine_en);
  p_busoff_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_evt |=> halt_status && node_busoff);
  p_busoff_implies_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    node_busoff |-> halt_status);
  p_defer_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_status && tx_busy && !busoff_evt) |=> !halt_status);
  p_defer_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_status && store_busy && !busoff_evt) |=> !halt_status);
  p_release_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_status) |-> $past(bit_tick) && $past(rx_level) && !$past(halt_wr_en));
  p_clear_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |-> !node_busoff && !halt_status && $past(node_busoff));
  p_clear_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |=> !err_clear);
  p_abort_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |-> halt_status && $past(rx_busy) && !$past(halt_status));
endmodule

bind can_halt_ctrl can_halt_ctrl_chk u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .halt_wr_en         (halt_wr_en),
  .bit_tick           (bit_tick),
  .rx_level           (rx_level),
  .tx_busy            (tx_busy),
  .rx_busy            (rx_busy),
  .store_busy         (store_busy),
  .busoff_evt         (busoff_evt),
  .halt_status        (halt_status),
  .tx_force_recessive (tx_force_recessive),
  .tx_engine_en       (tx_engine_en),
  .rx_engine_en       (rx_engine_en),
  .rx_abort           (rx_abort),
  .err_clear          (err_clear),
  .node_busoff        (node_busoff)
);

// File: tb/can_halt_ctrl_tb_top.sv
`timescale 1ns/1ps
module can_halt_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_wr_en = 1'b0, halt_wr_data = 1'b0, bit_tick = 1'b0, rx_level = 1'b1;
  logic tx_busy = 1'b0, rx_busy = 1'b0, store_busy = 1'b0, busoff_evt = 1'b0;
  logic halt_status, tx_force_recessive, tx_engine_en, rx_engine_en;
  logic rx_abort, err_clear, node_busoff;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state, from the requirements
  logic m_halt, m_busoff, m_pend, m_rec, m_clr, m_abort;
  int   m_bits, m_runs;

  always #2 clk = ~clk;

  can_halt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .halt_wr_en(halt_wr_en), .halt_wr_data(halt_wr_data),
    .bit_tick(bit_tick), .rx_level(rx_level), .tx_busy(tx_busy), .rx_busy(rx_busy),
    .store_busy(store_busy), .busoff_evt(busoff_evt), .halt_status(halt_status),
    .tx_force_recessive(tx_force_recessive), .tx_engine_en(tx_engine_en),
    .rx_engine_en(rx_engine_en), .rx_abort(rx_abort), .err_clear(err_clear),
    .node_busoff(node_busoff)
  );

  always @(posedge clk) begin
    m_clr   = 1'b0;
    m_abort = 1'b0;
    if (!rst_n) begin
      m_halt = 1; m_busoff = 0; m_pend = 0; m_rec = 0; m_bits = 0; m_runs = 0;
    end else if (busoff_evt) begin
      m_abort = !m_halt && rx_busy;
      m_halt = 1; m_busoff = 1; m_pend = 0; m_rec = 0; m_bits = 0; m_runs = 0;
    end else if (!m_halt) begin
      if ((m_pend || (halt_wr_en && halt_wr_data)) && !tx_busy && !store_busy) begin
        m_halt = 1; m_pend = 0; m_abort = rx_busy;
      end else if (halt_wr_en) begin
        m_pend = halt_wr_data;
      end
    end else if (!m_rec) begin
      if (halt_wr_en && !halt_wr_data) begin
        m_rec = 1; m_bits = 0; m_runs = 0;
      end
    end else if (halt_wr_en && halt_wr_data) begin
      m_rec = 0; m_bits = 0; m_runs = 0;
    end else if (bit_tick) begin
      if (!rx_level) m_bits = 0;
      else if (m_bits == 10) begin
        m_bits = 0;
        if (!m_busoff) begin
          m_halt = 0; m_rec = 0;
        end else if (m_runs == 127) begin
          m_halt = 0; m_rec = 0; m_busoff = 0; m_clr = 1; m_runs = 0;
        end else m_runs = m_runs + 1;
      end else m_bits = m_bits + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    if (rst_n) begin
      chk("R2", "halt_status vs model", halt_status, m_halt);
      chk("R6", "node_busoff vs model", node_busoff, m_busoff);
      chk("R9", "err_clear vs model", err_clear, m_clr);
      chk("R2", "rx_abort vs model", rx_abort, m_abort);
      chk("R11", "gates vs model", {tx_force_recessive, tx_engine_en, rx_engine_en},
          {m_halt, !m_halt, !m_halt});
    end
  endtask

  task automatic wr(input logic d);
    halt_wr_en = 1'b1; halt_wr_data = d;
    cyc();
    halt_wr_en = 1'b0;
  endtask

  task automatic tick(input logic lvl);
    bit_tick = 1'b1; rx_level = lvl;
    cyc();
    bit_tick = 1'b0; rx_level = 1'b1;
  endtask

  task automatic ticks(input int n, input logic lvl);
    for (int i = 0; i < n; i++) tick(lvl);
  endtask

  task automatic release_sw();
    wr(1'b0);
    ticks(11, 1'b1);
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "halt in reset", halt_status, 1);
    chk("R1", "busoff in reset", node_busoff, 0);
    chk("R1", "tx recessive in reset", tx_force_recessive, 1);
    chk("R1", "engines off in reset", {tx_engine_en, rx_engine_en}, 0);
    rst_n = 1'b1;
    cyc();

    // R7: release after reset halt
    wr(1'b0);
    ticks(10, 1'b1);
    chk("R7", "halted after 10 ticks", halt_status, 1);
    tick(1'b1);
    chk("R7", "released after 11 ticks", halt_status, 0);
    chk("R11", "tx engine enabled", tx_engine_en, 1);

    // R11: write 0 while running has no effect
    wr(1'b0); cyc(); cyc();
    chk("R11", "write 0 while running", halt_status, 0);

    // R2 and R8
    wr(1'b1);
    chk("R2", "immediate halt", halt_status, 1);
    wr(1'b0);
    ticks(5, 1'b1); tick(1'b0); ticks(10, 1'b1);
    chk("R8", "dominant restarted count", halt_status, 1);
    tick(1'b1);
    chk("R8", "released after fresh run", halt_status, 0);

    rx_busy = 1'b1;
    wr(1'b1);
    chk("R2", "halt during reception", halt_status, 1);
    chk("R2", "rx_abort pulse", rx_abort, 1);
    chk("R2", "rx engine off", rx_engine_en, 0);
    rx_busy = 1'b0;
    cyc();
    chk("R2", "rx_abort one cycle", rx_abort, 0);
    release_sw();

    // R3
    tx_busy = 1'b1;
    wr(1'b1);
    cyc(); cyc();
    chk("R3", "deferred while tx busy", halt_status, 0);
    tx_busy = 1'b0;
    cyc();
    chk("R3", "halt after tx done", halt_status, 1);
    release_sw();

    // R4
    tx_busy = 1'b1; store_busy = 1'b1;
    wr(1'b1);
    tx_busy = 1'b0;
    cyc();
    chk("R4", "deferred while storing", halt_status, 0);
    store_busy = 1'b0;
    cyc();
    chk("R4", "halt after store done", halt_status, 1);
    release_sw();
    tx_busy = 1'b1; store_busy = 1'b1;
    wr(1'b1);
    cyc();
    tx_busy = 1'b0; store_busy = 1'b0;
    cyc();
    chk("R4", "halt on joint done", halt_status, 1);
    release_sw();

    // R5
    tx_busy = 1'b1;
    wr(1'b1); wr(1'b0);
    tx_busy = 1'b0;
    cyc(); cyc();
    chk("R5", "pending halt cancelled", halt_status, 0);

    // R10
    wr(1'b1);
    wr(1'b0);
    ticks(6, 1'b1);
    wr(1'b1);
    ticks(8, 1'b1);
    chk("R10", "aborted recovery stays halted", halt_status, 1);
    wr(1'b0);
    ticks(10, 1'b1);
    chk("R10", "count restarted", halt_status, 1);
    tick(1'b1);
    chk("R10", "released after restart", halt_status, 0);

    // R6 and R9
    tx_busy = 1'b1;
    busoff_evt = 1'b1;
    cyc();
    busoff_evt = 1'b0; tx_busy = 1'b0;
    chk("R6", "busoff halts", halt_status, 1);
    chk("R6", "busoff state", node_busoff, 1);
    wr(1'b0);
    ticks(127 * 11, 1'b1);
    chk("R9", "127 runs not enough", halt_status, 1);
    ticks(10, 1'b1);
    chk("R9", "still bus off", node_busoff, 1);
    tick(1'b1);
    chk("R9", "released after 128 runs", halt_status, 0);
    chk("R9", "error active", node_busoff, 0);
    chk("R9", "clear pulse", err_clear, 1);
    cyc();
    chk("R9", "clear pulse one cycle", err_clear, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      halt_wr_en   = ($urandom % 30) == 0;
      halt_wr_data = $urandom % 2;
      bit_tick     = $urandom % 2;
      rx_level     = ($urandom % 10) != 0;
      busoff_evt   = ($urandom % 700) == 0;
      if (($urandom % 6) == 0) tx_busy = ~tx_busy;
      if (($urandom % 7) == 0) store_busy = ~store_busy;
      if (($urandom % 5) == 0) rx_busy = ~rx_busy;
      cyc();
    end
    halt_wr_en = 0; busoff_evt = 0; bit_tick = 0;
    cyc();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule